// File: doc/BRIEF.md
# Idle Clock-Gate Wake Controller

This block decides when a processor cluster's clock may be stopped while the core sits halted in wait-for-interrupt, and when it must run again. A small three-state machine moves from running to gated only while the power sequencer reports normal operation. Once gated, it leaves that state only on reset, on any interrupt source, or on a pending snoop from the coherent interconnect. The gate request is registered, so it follows the machine's state one clock later. The final clock enable combines that request with a power-down gate request from the sequencer.

A pending snoop reaches the enable without passing through a register. The clock therefore runs in the same cycle the snoop shows up, whatever the registers hold. A build parameter can turn idle gating off entirely. In that build the gate request never leaves zero and only the power-down path and the snoop bypass remain. The clock-gating cell and the interrupt controllers sit outside this block.

Top module: `wfi_clk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the gate request is zero after that edge. Out of reset, with no power-down request, `clk_en_o` is 1.
- R2: In the running state, if `wfi_i` and `pwr_normal_i` are both 1 and no wake source or snoop is pending at an edge, the machine enters the gated state. `gate_req_o` becomes 1 after the following edge and `clk_en_o` becomes 0. A pending wake source at that edge keeps the machine running.
- R3: While `pwr_normal_i` is 0 the machine never enters the gated state, even with `wfi_i` at 1.
- R4: In the gated state, any single bit of `wake_src_i` ends gating: the machine enters the awake state at that edge and `gate_req_o` returns to 0 after the next edge. The bit positions are [6] machine software, [5] machine timer, [4] machine external, [3] supervisor external, [2] first non-maskable, [1] second non-maskable, [0] message-signalled interrupt valid.
- R5: `snoop_pend_i` at 1 forces `clk_en_o` to 1 in the same cycle, even while the gate request or the power-down request is active. It also wakes the machine, with the same timing as R4.
- R6: Dropping `wfi_i` alone, with no wake source and no snoop, does not leave the gated state.
- R7: From the awake state the machine returns to running only once `wfi_i` is 0. While `wfi_i` stays 1 it does not gate again. After `wfi_i` falls and rises again it gates as in R2.
- R8: `pd_gate_i` at 1 with no snoop forces `clk_en_o` to 0.
- R9: With parameter `GATE_EN` at 0, `gate_req_o` stays 0 under any stimulus, and `clk_en_o` equals (not `pd_gate_i`) or `snoop_pend_i`.
- R10: A reset applied while gated clears the gate request at the reset edge and returns the machine to the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock (free running, before the gate cell) |
| rst_n | input | 1 | Synchronous active-low cluster reset |
| wfi_i | input | 1 | Core halted in wait-for-interrupt |
| pwr_normal_i | input | 1 | Power sequencer in its normal (idle) state |
| snoop_pend_i | input | 1 | Snoop flit pending on the interconnect receive channel |
| wake_src_i | input | 7 | Packed interrupt wake sources (positions in R4) |
| pd_gate_i | input | 1 | Gate request from the power-down sequence |
| gate_req_o | output | 1 | Registered idle gate request |
| clk_en_o | output | 1 | Final enable for the clock-gating cell |

## Verification
The state machine has no direct output, so a wrong state shows up only through `gate_req_o`, one edge after the state changes, and through `clk_en_o` in that same cycle. A machine that is stuck gated or woken too early is therefore visible two edges after the stimulus that should have moved it. A missed or extra snoop bypass is visible in the very cycle the snoop is driven. The bench runs a gating and a non-gating build side by side. The gated build exposes the state timing, and the non-gating build pins down the combinational enable path.

// File: rtl/wcg_pkg.sv
// Shared definitions for the idle clock-gate wake controller.
// Assumes two state bits are enough for the three-state protocol.
package wcg_pkg;

    typedef enum logic [1:0] {
        WCG_RUN   = 2'd0,
        WCG_GATED = 2'd1,
        WCG_AWAKE = 2'd2
    } wcg_state_e;

endpackage

// File: rtl/wcg_wake_merge.sv
// Merges the packed interrupt wake vector and the snoop pending flag into
// a single wake event. Assumes every source is level and already
// synchronous to clk.
module wcg_wake_merge #(
    parameter int SRC_W = 7
) (
    input  logic [SRC_W-1:0] wake_src,
    input  logic             snoop_pend,
    output logic             irq_any,
    output logic             wake_any
);

    logic [SRC_W:0] chain;

    assign chain[0] = 1'b0;

    // OR-reduce the sources as an explicit chain, one stage per source
    for (genvar i = 0; i < SRC_W; i++) begin : g_or
        assign chain[i+1] = chain[i] | wake_src[i];
    end

    // Interrupt-only wake and combined wake with the snoop
    always_comb begin
        irq_any  = chain[SRC_W];
        wake_any = chain[SRC_W] | snoop_pend;
    end

endmodule

// File: rtl/wcg_state_fsm.sv
// Three-state idle gating protocol: RUN -> GATED -> AWAKE -> RUN.
// Gating starts only in normal power state with no wake pending. Only a
// wake event (or reset) leaves GATED. AWAKE waits for WFI to drop.
module wcg_state_fsm
    import wcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi,
    input  logic       pwr_normal,
    input  logic       wake_any,
    output wcg_state_e state
);

    wcg_state_e state_nxt;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            WCG_RUN:   if (wfi && pwr_normal && !wake_any) state_nxt = WCG_GATED;
            WCG_GATED: if (wake_any)                       state_nxt = WCG_AWAKE;
            WCG_AWAKE: if (!wfi)                           state_nxt = WCG_RUN;
            default:                                       state_nxt = WCG_RUN;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WCG_RUN;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/wcg_gate_out.sv
// Registers the idle gate request from the state and forms the final
// clock enable. GATE_EN selects whether idle gating exists at all.
// Assumes pd_gate is already registered by the power sequencer.
module wcg_gate_out
    import wcg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wcg_state_e state,
    input  logic       pd_gate,
    input  logic       snoop_pend,
    output logic       gate_req,
    output logic       clk_en
);

    if (GATE_EN) begin : g_gate
        // Gate request follows the GATED state one cycle later
        always_ff @(posedge clk) begin
            if (!rst_n) gate_req <= 1'b0;
            else        gate_req <= (state == WCG_GATED);
        end
    end else begin : g_nogate
        // Idle gating removed: request tied low
        assign gate_req = 1'b0;
    end

    // Final enable: snoop bypasses both gate sources in the same cycle
    always_comb begin
        clk_en = (!gate_req && !pd_gate) || snoop_pend;
    end

endmodule

// File: rtl/wfi_clk_gate_ctrl.sv
// Top of the idle clock-gate wake controller. It wires the wake merge,
// the state machine and the gate output stage together. All inputs are
// assumed synchronous to clk, the free-running clock ahead of the gate cell.
module wfi_clk_gate_ctrl
    import wcg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1,
    parameter int SRC_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_i,
    input  logic             pwr_normal_i,
    input  logic             snoop_pend_i,
    input  logic [SRC_W-1:0] wake_src_i,
    input  logic             pd_gate_i,
    output logic             gate_req_o,
    output logic             clk_en_o
);

    logic       irq_any;
    logic       wake_any;
    wcg_state_e state;

    wcg_wake_merge #(.SRC_W(SRC_W)) u_merge (
        .wake_src   (wake_src_i),
        .snoop_pend (snoop_pend_i),
        .irq_any    (irq_any),
        .wake_any   (wake_any)
    );

    wcg_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi        (wfi_i),
        .pwr_normal (pwr_normal_i),
        .wake_any   (wake_any),
        .state      (state)
    );

    wcg_gate_out #(.GATE_EN(GATE_EN)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .pd_gate    (pd_gate_i),
        .snoop_pend (snoop_pend_i),
        .gate_req   (gate_req_o),
        .clk_en     (clk_en_o)
    );

endmodule

// File: rtl/wcg_checker.sv
// Port-level properties of the idle clock-gate wake controller. It is bound
// to every instance of the top module.
module wcg_checker #(
    parameter int SRC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wfi_i,
    input logic             pwr_normal_i,
    input logic             snoop_pend_i,
    input logic [SRC_W-1:0] wake_src_i,
    input logic             pd_gate_i,
    input logic             gate_req_o,
    input logic             clk_en_o
);

    // R1: reset clears the gate request at the reset edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !gate_req_o);

    // R2, R3: a new gate request needs WFI and normal power two edges back
    a_r3_entry_needs_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_req_o) && $past(rst_n) && $past(rst_n, 2))
            |-> ($past(wfi_i, 2) && $past(pwr_normal_i, 2)));

    // R4: a wake source seen while gated removes the request within two edges
    a_r4_wake_ends_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_req_o && (|wake_src_i)) |=> ##1 !gate_req_o);

    // R5: a pending snoop always opens the clock
    a_r5_snoop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_pend_i |-> clk_en_o);

    // R6: gating only ends through a wake event
    a_r6_only_wake_ungates: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_req_o) && $past(rst_n) && $past(rst_n, 2))
            |-> $past((|wake_src_i) || snoop_pend_i, 2));

    // R8: a power-down request closes the clock unless a snoop is pending
    a_r8_pd_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_gate_i && !snoop_pend_i) |-> !clk_en_o);

endmodule

bind wfi_clk_gate_ctrl wcg_checker #(.SRC_W(SRC_W)) u_wcg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wfi_i        (wfi_i),
    .pwr_normal_i (pwr_normal_i),
    .snoop_pend_i (snoop_pend_i),
    .wake_src_i   (wake_src_i),
    .pd_gate_i    (pd_gate_i),
    .gate_req_o   (gate_req_o),
    .clk_en_o     (clk_en_o)
);

// File: tb/test_wfi_clk_gate_ctrl.sv
`timescale 1ns/1ps
module test_wfi_clk_gate_ctrl;

    localparam int SRC_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wfi;
    logic             pwr_normal;
    logic             snoop;
    logic [SRC_W-1:0] wake;
    logic             pd;
    logic             gr, ce;
    logic             gr0, ce0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wfi_clk_gate_ctrl #(.GATE_EN(1'b1), .SRC_W(SRC_W)) i_wfi_clk_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .pwr_normal_i(pwr_normal),
        .snoop_pend_i(snoop), .wake_src_i(wake), .pd_gate_i(pd),
        .gate_req_o(gr), .clk_en_o(ce));

    wfi_clk_gate_ctrl #(.GATE_EN(1'b0), .SRC_W(SRC_W)) i_wfi_clk_gate_ctrl_nogate (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .pwr_normal_i(pwr_normal),
        .snoop_pend_i(snoop), .wake_src_i(wake), .pd_gate_i(pd),
        .gate_req_o(gr0), .clk_en_o(ce0));

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge (one rising edge passed)
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R9: the non-gating build never requests and follows the enable equation
    task automatic chk_nogate(input string tag);
        chk(gr0, 1'b0, "R9", {tag, " nogate gate_req"});
        chk(ce0, (!pd) || snoop, "R9", {tag, " nogate clk_en"});
    endtask

    task automatic go_gated();
        wfi = 1'b1; pwr_normal = 1'b1; wake = '0; snoop = 1'b0;
        step();
        chk(gr, 1'b0, "R2", "gate_req one edge after entry");
        step();
        chk(gr, 1'b1, "R2", "gate_req two edges after entry");
        chk(ce, 1'b0, "R2", "clk_en while gated");
        chk_nogate("entry");
    endtask

    task automatic back_to_run();
        wake = '0; snoop = 1'b0; wfi = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wfi = 1'b0; pwr_normal = 1'b1; snoop = 1'b0; wake = '0; pd = 1'b0;
        step(3);
        chk(gr, 1'b0, "R1", "gate_req in reset");
        rst_n = 1'b1;
        step();
        chk(gr, 1'b0, "R1", "gate_req after reset");
        chk(ce, 1'b1, "R1", "clk_en after reset");
        chk_nogate("reset");
    endtask

    // R4: every wake bit, one at a time
    task automatic t_each_wake_bit();
        for (int b = 0; b < SRC_W; b++) begin
            go_gated();
            wake = SRC_W'(1) << b;
            step();
            chk(gr, 1'b1, "R4", $sformatf("bit %0d gate_req one edge after wake", b));
            step();
            chk(gr, 1'b0, "R4", $sformatf("bit %0d gate_req two edges after wake", b));
            chk(ce, 1'b1, "R4", $sformatf("bit %0d clk_en after wake", b));
            back_to_run();
        end
    endtask

    task automatic t_not_normal();
        pwr_normal = 1'b0; wfi = 1'b1;
        step(4);
        chk(gr, 1'b0, "R3", "no gating outside normal power");
        chk(ce, 1'b1, "R3", "clock runs outside normal power");
        wfi = 1'b0; pwr_normal = 1'b1;
        step();
    endtask

    task automatic t_entry_blocked();
        wake = 7'b0000100; wfi = 1'b1; pwr_normal = 1'b1;
        step(4);
        chk(gr, 1'b0, "R2", "pending wake blocks entry");
        wake = '0;
        step(2);
        chk(gr, 1'b1, "R2", "entry once wake clears");
        wake = 7'b1000000;
        step(2);
        back_to_run();
    endtask

    task automatic t_wfi_drop();
        go_gated();
        wfi = 1'b0;
        step(4);
        chk(gr, 1'b1, "R6", "WFI drop alone keeps gating");
        chk(ce, 1'b0, "R6", "clock stays closed");
        wake = 7'b0000001;
        step(2);
        chk(gr, 1'b0, "R6", "wake after WFI drop ungates");
        back_to_run();
    endtask

    task automatic t_awake_hold();
        go_gated();
        wake = 7'b0100000;
        step();
        wake = '0;
        step();
        chk(gr, 1'b0, "R7", "ungated after pulse");
        step(4);
        chk(gr, 1'b0, "R7", "no re-gate while WFI held");
        wfi = 1'b0;
        step();
        wfi = 1'b1;
        step(2);
        chk(gr, 1'b1, "R7", "re-gate after WFI toggles");
        wake = 7'b0010000;
        step(2);
        back_to_run();
    endtask

    task automatic t_snoop();
        go_gated();
        snoop = 1'b1; pd = 1'b1;
        #1;
        chk(ce, 1'b1, "R5", "snoop opens clock same cycle");
        chk(gr, 1'b1, "R5", "gate_req unchanged same cycle");
        chk_nogate("snoop");
        step();
        snoop = 1'b0;
        #1;
        chk(ce, 1'b0, "R8", "pd closes clock after snoop");
        pd = 1'b0;
        step();
        chk(gr, 1'b0, "R5", "snoop wakes the machine");
        back_to_run();
    endtask

    task automatic t_pd();
        pd = 1'b1;
        #1;
        chk(ce, 1'b0, "R8", "pd closes clock");
        chk_nogate("pd");
        pd = 1'b0;
        #1;
        chk(ce, 1'b1, "R8", "clock reopens after pd");
        step();
    endtask

    task automatic t_reset_gated();
        go_gated();
        rst_n = 1'b0;
        step();
        chk(gr, 1'b0, "R10", "reset clears gating");
        rst_n = 1'b1; wfi = 1'b0;
        step(2);
        chk(gr, 1'b0, "R10", "running after reset");
        chk(ce, 1'b1, "R10", "clock runs after reset");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_entry_blocked();
        t_each_wake_bit();
        t_not_normal();
        t_wfi_drop();
        t_awake_hold();
        t_snoop();
        t_pd();
        t_reset_gated();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule